// File: doc/BRIEF.md
# Supervisory Watchdog with Safe-Frequency Fallback

This block watches over a running system by counting a slow time-base tick and expecting software to service it before a programmable deadline. The deadline is a 3-bit multiplier times one of two base periods, short (290 ms) or long (1160 ms). Both bases are written as tick counts, so a scaled tick keeps simulation short. When the watchdog is disabled, nothing counts. Software services it with a kick strobe, and any change to the multiplier or the base selection also restarts the count.

If the deadline passes, the block raises an alarm. It replaces the frequency-select code it passes on with a programmed safe code that uses the same 5-bit encoding, and it drives an active-low system reset pulse of fixed length. The alarm holds, and counting stops, until the enable is dropped. Any change of the forwarded frequency code is a change of gear ratio and also produces the reset pulse, whether the source code changed, the alarm switched codes, or the safe code was altered while the alarm holds.

On the register side, the multiplier would reset to 7 with the short base selected, giving a deadline of about 2 s, and the enable would reset to 0. Those fields live outside this block and arrive here as plain inputs.

Top module: `wdg_safefreq_top`

## Requirements
- R1: During reset and immediately after it, `alarm` is 0 and `sys_rst_n` is 1. One cycle after reset releases, `eff_code` equals `cur_code`, with no reset pulse.
- R2: While `wd_en` is 0, ticks never raise `alarm`.
- R3: With `wd_en` high, `alarm` rises on the clock edge that samples the L-th tick since the last reload. L = `mult` × B, with B = BASE_SHORT_TICKS (29) when `base_sel`=0 and BASE_LONG_TICKS (116) when `base_sel`=1. A `mult` of 0 times out on the first tick.
- R4: A `kick` pulse restarts the count from zero. A kick sampled in the same cycle as a tick wins, and that tick is not counted.
- R5: A change of `mult` or `base_sel` restarts the count from zero, exactly as a kick does.
- R6: Once set, `alarm` holds while `wd_en` stays high, and no further timeout occurs. Dropping `wd_en` clears `alarm` on the next edge.
- R7: `eff_code` is registered. It shows `safe_code` while the alarm is set and `cur_code` otherwise, one cycle after the inputs.
- R8: `sys_rst_n` goes low on the same edge at which `alarm` rises. It returns high on the edge that samples the RST_TICKS-th (4) tick after that edge.
- R9: A change of `eff_code` (a gear change) starts the same reset pulse. A change of `cur_code` while the alarm holds does not change `eff_code`, so it causes no pulse.
- R10: A new trigger during a pulse restarts the pulse length, and the tick count is taken from the last trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe |
| wd_en | input | 1 | Watchdog enable |
| base_sel | input | 1 | 0: short base, 1: long base |
| mult | input | MULT_W | Deadline multiplier |
| safe_code | input | CODE_W | Frequency code used while alarmed |
| cur_code | input | CODE_W | Frequency code in normal operation |
| kick | input | 1 | Service strobe, restarts the count |
| alarm | output | 1 | Timeout status |
| eff_code | output | CODE_W | Forwarded frequency code |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The hardest corner to reach from the ports is the exact boundary of a deadline that was moved partway through. The count is restarted by a kick or a field change, and the kick may share a cycle with a tick. The stimulus drives each tick as a single-cycle strobe. It places kicks, kick-plus-tick cycles and base changes at chosen tick counts, then probes one tick before and on the deadline. Random trials pick multiplier, base, kick position and a final tick count around the deadline, and the bench computes the expected alarm state for each.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic {
      WDG_BASE_SHORT = 1'b0,
      WDG_BASE_LONG  = 1'b1
   } wdg_base_e;

   typedef enum int {
      WDG_MUL_OPERATOR = 0,
      WDG_MUL_SHIFTADD = 1
   } wdg_mul_style_e;
endpackage

// File: rtl/wdg_limit_calc.sv
module wdg_limit_calc
   import wdg_pkg::*;
#(
   parameter int MULT_W      = 3,
   parameter int BASE_SHORT  = 29,
   parameter int BASE_LONG   = 116,
   parameter int CNT_W       = 10,
   parameter int MUL_STYLE   = WDG_MUL_SHIFTADD
) (
   input  logic              base_sel,
   input  logic [MULT_W-1:0] mult,
   output logic [CNT_W-1:0]  limit
);
   logic [CNT_W-1:0] base_val;
   wdg_base_e        base_e;

   assign base_e   = wdg_base_e'(base_sel);
   assign base_val = (base_e == WDG_BASE_LONG) ? CNT_W'(BASE_LONG) : CNT_W'(BASE_SHORT);

   generate
      if (MUL_STYLE == WDG_MUL_OPERATOR) begin : g_mul_op
         assign limit = CNT_W'(mult) * base_val;
      end else begin : g_mul_sa
         always_comb begin
            limit = '0;
            for (int i = 0; i < MULT_W; i++) begin
               if (mult[i]) limit = limit + (base_val << i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             reload,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt_q + CNT_W'(1);
   assign expire  = run && tick && !reload && (cnt_inc >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (reload || expire) begin
         cnt_q <= '0;
      end else if (run && tick) begin
         cnt_q <= cnt_inc;
      end
   end
endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
   parameter int RST_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic trig,
   output logic active
);
   localparam int PW = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;

   logic [PW-1:0] pcnt_q;
   logic          active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pcnt_q   <= '0;
      end else if (trig) begin
         active_q <= 1'b1;
         pcnt_q   <= '0;
      end else if (active_q && tick) begin
         if (pcnt_q == PW'(RST_TICKS - 1)) begin
            active_q <= 1'b0;
            pcnt_q   <= '0;
         end else begin
            pcnt_q <= pcnt_q + PW'(1);
         end
      end
   end

   assign active = active_q;
endmodule

// File: rtl/wdg_safefreq_top.sv
module wdg_safefreq_top
   import wdg_pkg::*;
#(
   parameter int CODE_W           = 5,
   parameter int MULT_W           = 3,
   parameter int BASE_SHORT_TICKS = 29,
   parameter int BASE_LONG_TICKS  = 116,
   parameter int RST_TICKS        = 4,
   parameter int MUL_STYLE        = WDG_MUL_SHIFTADD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wd_en,
   input  logic              base_sel,
   input  logic [MULT_W-1:0] mult,
   input  logic [CODE_W-1:0] safe_code,
   input  logic [CODE_W-1:0] cur_code,
   input  logic              kick,
   output logic              alarm,
   output logic [CODE_W-1:0] eff_code,
   output logic              sys_rst_n
);
   localparam int MAX_MULT  = (1 << MULT_W) - 1;
   localparam int MAX_BASE  = (BASE_LONG_TICKS > BASE_SHORT_TICKS) ? BASE_LONG_TICKS : BASE_SHORT_TICKS;
   localparam int MAX_LIMIT = MAX_MULT * MAX_BASE;
   localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

   generate
      if (CODE_W < 1) begin : g_bad_code
         $error("CODE_W must be at least 1");
      end
      if (MULT_W < 1 || MULT_W > 8) begin : g_bad_mult
         $error("MULT_W must be 1..8");
      end
      if (BASE_SHORT_TICKS < 1 || BASE_LONG_TICKS < 1) begin : g_bad_base
         $error("base tick counts must be positive");
      end
      if (RST_TICKS < 1) begin : g_bad_rst
         $error("RST_TICKS must be positive");
      end
      if (MUL_STYLE != WDG_MUL_OPERATOR && MUL_STYLE != WDG_MUL_SHIFTADD) begin : g_bad_style
         $error("unknown MUL_STYLE");
      end
   endgenerate

   logic              primed_q;
   logic [MULT_W-1:0] mult_q;
   logic              sel_q;
   logic              alarm_q;
   logic [CODE_W-1:0] eff_q;
   logic [CNT_W-1:0]  limit;
   logic              cfg_chg;
   logic              reload;
   logic              run;
   logic              expire;
   logic              alarm_next;
   logic [CODE_W-1:0] eff_next;
   logic              gear_chg;
   logic              pulse_trig;
   logic              pulse_active;

   wdg_limit_calc #(
      .MULT_W    (MULT_W),
      .BASE_SHORT(BASE_SHORT_TICKS),
      .BASE_LONG (BASE_LONG_TICKS),
      .CNT_W     (CNT_W),
      .MUL_STYLE (MUL_STYLE)
   ) u_limit (
      .base_sel(base_sel),
      .mult    (mult),
      .limit   (limit)
   );

   assign cfg_chg = primed_q && ((mult != mult_q) || (base_sel != sel_q));
   assign reload  = !wd_en || kick || cfg_chg;
   assign run     = wd_en && !alarm_q;

   wdg_tick_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .run   (run),
      .reload(reload),
      .limit (limit),
      .expire(expire)
   );

   assign alarm_next = wd_en && (alarm_q || expire);
   assign eff_next   = alarm_next ? safe_code : cur_code;
   assign gear_chg   = primed_q && (eff_next != eff_q);
   assign pulse_trig = expire || gear_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q <= 1'b0;
         mult_q   <= '0;
         sel_q    <= 1'b0;
         alarm_q  <= 1'b0;
         eff_q    <= '0;
      end else begin
         primed_q <= 1'b1;
         mult_q   <= mult;
         sel_q    <= base_sel;
         alarm_q  <= alarm_next;
         eff_q    <= eff_next;
      end
   end

   wdg_rst_pulse #(
      .RST_TICKS(RST_TICKS)
   ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .trig  (pulse_trig),
      .active(pulse_active)
   );

   assign alarm     = alarm_q;
   assign eff_code  = eff_q;
   assign sys_rst_n = !pulse_active;
endmodule

// File: rtl/wdg_safefreq_chk.sv
module wdg_safefreq_chk #(
   parameter int CODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wd_en,
   input logic [CODE_W-1:0] safe_code,
   input logic              alarm,
   input logic [CODE_W-1:0] eff_code,
   input logic              sys_rst_n
);
   // R6: dropping the enable clears the alarm
   a_r6_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_en |=> !alarm);

   // R6: alarm holds while enabled
   a_r6_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm && wd_en) |=> alarm);

   // R3: a timeout is only ever caused by a tick sampled while enabled
   a_r3_alarm_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm) |-> ($past(tick) && $past(wd_en)));

   // R8: reset goes low together with the alarm
   a_r8_reset_on_alarm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm) |-> !sys_rst_n);

   // R8: reset is only released by a tick
   a_r8_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_n) |-> $past(tick));

   // R7: safe code is forwarded while alarmed
   a_r7_safe_code: assert property (@(posedge clk) disable iff (!rst_n)
      alarm |-> (eff_code == $past(safe_code)));
endmodule

bind wdg_safefreq_top wdg_safefreq_chk #(.CODE_W(CODE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .wd_en    (wd_en),
   .safe_code(safe_code),
   .alarm    (alarm),
   .eff_code (eff_code),
   .sys_rst_n(sys_rst_n)
);

// File: tb/wdg_safefreq_top_tb_top.sv
module wdg_safefreq_top_tb_top;
   localparam int CODE_W = 5;
   localparam int MULT_W = 3;
   localparam int BS     = 29;
   localparam int BL     = 116;
   localparam int RT     = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic              wd_en = 1'b0;
   logic              base_sel = 1'b0;
   logic [MULT_W-1:0] mult = 3'd7;
   logic [CODE_W-1:0] safe_code = 5'h1A;
   logic [CODE_W-1:0] cur_code = 5'h03;
   logic              kick = 1'b0;
   logic              alarm;
   logic [CODE_W-1:0] eff_code;
   logic              sys_rst_n;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   wdg_safefreq_top #(
      .CODE_W(CODE_W), .MULT_W(MULT_W), .BASE_SHORT_TICKS(BS),
      .BASE_LONG_TICKS(BL), .RST_TICKS(RT)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wd_en(wd_en), .base_sel(base_sel),
      .mult(mult), .safe_code(safe_code), .cur_code(cur_code), .kick(kick),
      .alarm(alarm), .eff_code(eff_code), .sys_rst_n(sys_rst_n)
   );

   function automatic int exp_limit(int m, int sel);
      return m * (sel != 0 ? BL : BS);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic do_kick();
      @(negedge clk) kick = 1'b1;
      @(negedge clk) kick = 1'b0;
   endtask

   task automatic disarm();
      @(negedge clk) wd_en = 1'b0;
      cyc(1);
      ticks(RT);
   endtask

   task automatic arm(int m, int sel);
      @(negedge clk);
      mult = 3'(m);
      base_sel = sel[0];
      cyc(1);
      wd_en = 1'b1;
   endtask

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog: run did not complete, got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      cyc(3);
      check("R1 alarm in reset", alarm, 0);
      check("R1 sys_rst_n in reset", sys_rst_n, 1);
      rst_n = 1'b1;
      cyc(2);
      check("R1 alarm after reset", alarm, 0);
      check("R1 no pulse after reset", sys_rst_n, 1);
      check("R1 eff_code after reset", eff_code, 5'h03);

      // R2: disabled watchdog ignores ticks
      ticks(1000);
      check("R2 alarm while disabled", alarm, 0);
      check("R2 no pulse while disabled", sys_rst_n, 1);

      // R3 default deadline 7*29
      arm(7, 0);
      ticks(exp_limit(7, 0) - 1);
      check("R3 before deadline", alarm, 0);
      ticks(1);
      check("R3 at deadline", alarm, 1);
      check("R7 safe code forwarded", eff_code, 5'h1A);
      check("R8 reset low at timeout", sys_rst_n, 0);
      ticks(RT - 1);
      check("R8 reset still low", sys_rst_n, 0);
      ticks(1);
      check("R8 reset released", sys_rst_n, 1);
      ticks(300);
      check("R6 alarm held", alarm, 1);
      check("R6 no second timeout", sys_rst_n, 1);
      // R9: cur_code change while alarmed has no effect
      @(negedge clk) cur_code = 5'h07;
      cyc(2);
      check("R9 eff_code kept during alarm", eff_code, 5'h1A);
      check("R9 no pulse during alarm", sys_rst_n, 1);
      @(negedge clk) wd_en = 1'b0;
      cyc(1);
      check("R6 alarm cleared", alarm, 0);
      check("R7 cur code back", eff_code, 5'h07);
      check("R9 gear pulse on code return", sys_rst_n, 0);
      ticks(RT);
      check("R9 gear pulse ends", sys_rst_n, 1);

      // R3 mult 0
      arm(0, 1);
      ticks(1);
      check("R3 mult zero first tick", alarm, 1);
      disarm();

      // R4 kick
      arm(2, 0);
      ticks(50);
      do_kick();
      ticks(50);
      check("R4 kick restarted count", alarm, 0);
      ticks(8);
      check("R4 deadline after kick", alarm, 1);
      disarm();
      arm(2, 0);
      ticks(57);
      @(negedge clk) begin tick = 1'b1; kick = 1'b1; end
      @(negedge clk) begin tick = 1'b0; kick = 1'b0; end
      ticks(57);
      check("R4 kick beats tick", alarm, 0);
      ticks(1);
      check("R4 deadline after kick+tick", alarm, 1);
      disarm();

      // R5 field change reloads
      arm(1, 0);
      ticks(20);
      @(negedge clk) base_sel = 1'b1;
      ticks(115);
      check("R5 base change reloads", alarm, 0);
      ticks(1);
      check("R5 deadline with new base", alarm, 1);
      disarm();
      arm(3, 0);
      ticks(80);
      @(negedge clk) mult = 3'd1;
      ticks(28);
      check("R5 mult change reloads", alarm, 0);
      ticks(1);
      check("R5 deadline with new mult", alarm, 1);
      disarm();

      // R9 gear change while normal, R10 retrigger
      @(negedge clk) cur_code = 5'h11;
      cyc(1);
      check("R7 eff follows cur", eff_code, 5'h11);
      check("R9 gear change pulse", sys_rst_n, 0);
      ticks(2);
      @(negedge clk) cur_code = 5'h12;
      cyc(1);
      ticks(RT - 1);
      check("R10 pulse restarted", sys_rst_n, 0);
      ticks(1);
      check("R10 pulse ends after restart", sys_rst_n, 1);

      // random trials for R3/R4
      for (int t = 0; t < 12; t++) begin
         int m, s, lim, k, n;
         m   = $urandom_range(1, 7);
         s   = $urandom_range(0, 1);
         lim = exp_limit(m, s);
         k   = $urandom_range(1, lim - 1);
         n   = lim - 2 + $urandom_range(0, 3);
         arm(m, s);
         ticks(k);
         do_kick();
         ticks(n);
         check("R3 random deadline", alarm, (n >= lim) ? 1 : 0);
         disarm();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule